// File: doc/BRIEF.md
# CRTC Raster Timing Generator

This block drives a display raster from timing values that use the classic VGA encodings. The horizontal values count 8-pixel characters. The stored total is five characters short of the real line length. Blanking and sync edges are found by matching the running character count against a start value and a truncated end value. The vertical values count scan lines. The stored total is two lines short of the real frame height, and the vertical edges are matched in the same way. The register front end has already merged any scattered high bits, so every input here arrives as a full-width count.

On every pixel clock the block steps a pixel-within-character counter, a character counter and a line counter. From these counters it produces horizontal and vertical sync, a combined blank, a pulse that marks the first pixel of each character, and the index of the current scan line. Each sync has its own polarity bit and its own force-off bit, which power management uses. A screen-off bit holds blank high continuously.

Top module: `crtc_timing`

## Requirements
- R1: Reset clears the pixel, character and line counters and the blank and sync state. In the first cycle after reset, blank is 0, both syncs are at their inactive level, raster_line is 0 and char_en is 1.
- R2: char_en is 1 on the first pixel of every 8-pixel character and 0 on the other seven pixels.
- R3: A line lasts (h_total + 5) characters and a frame lasts (v_total + 2) lines. raster_line gives the current line index, counting up from 0 and returning to 0 after the last line.
- R4: The horizontal blank covers the characters from h_blank_start + 1 up to and including the first character whose low 7 bits equal h_blank_end. That end match is only looked for while the blank is already active.
- R5: The horizontal sync becomes active on character h_sync_start. It goes inactive on the first later character whose low 5 bits equal h_sync_end, even when that character lies on the following line.
- R6: The vertical blank covers the lines from v_blank_start + 1 up to and including the first line whose low 8 bits equal v_blank_end. It goes inactive on the first character of the line that follows.
- R7: The vertical sync becomes active on line v_sync_start. It goes inactive on the first later line whose low 4 bits equal v_sync_end, even when that line lies in the following frame.
- R8: When a polarity input is 1, its sync output is active low. When it is 0, the sync output is active high.
- R9: When a sync-off input is 1, its sync output stays at the inactive level that its polarity selects.
- R10: When screen_off is 1, blank is 1 on every cycle.
- R11: blank is 1 whenever either the horizontal blank or the vertical blank is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_total | input | 9 | Line length in characters, minus 5 |
| h_blank_start | input | 9 | Last character before the horizontal blank |
| h_blank_end | input | 7 | Low 7 bits of the last blanked character |
| h_sync_start | input | 9 | First character of the horizontal sync |
| h_sync_end | input | 5 | Low 5 bits of the first character after the sync |
| v_total | input | 12 | Frame height in lines, minus 2 |
| v_blank_start | input | 12 | Last line before the vertical blank |
| v_blank_end | input | 8 | Low 8 bits of the last blanked line |
| v_sync_start | input | 12 | First line of the vertical sync |
| v_sync_end | input | 4 | Low 4 bits of the first line after the sync |
| hsync_neg | input | 1 | 1 makes hsync active low |
| vsync_neg | input | 1 | 1 makes vsync active low |
| hsync_off | input | 1 | 1 holds hsync inactive |
| vsync_off | input | 1 | 1 holds vsync inactive |
| screen_off | input | 1 | 1 holds blank high |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Combined blank |
| raster_line | output | 11 | Current scan line |
| char_en | output | 1 | First pixel of a character |

## Verification
The hardest situation to reach is an end value whose truncated bits match a character or line before the intended one. The other hard case is a pulse that runs across a line or frame boundary. Both only show up with long lines and with start and end values chosen so that the low bits alias. One scenario sets up a 135-character line for this. In that line, character 131 aliases the blank end while the blank is still inactive, and character 34 cuts the sync short through its 5-bit end. The vertical sync in the same scenario runs into the next frame. Checks for that scenario begin only once the first line and the first frame have passed, because before then the state started from reset rather than from a wrap.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int CRTC_H_W      = 9;
    localparam int CRTC_V_W      = 12;
    localparam int CRTC_CHAR_W   = 8;
    localparam int CRTC_RASTER_W = 11;
    localparam int CRTC_HBE_W    = 7;
    localparam int CRTC_HSE_W    = 5;
    localparam int CRTC_VBE_W    = 8;
    localparam int CRTC_VSE_W    = 4;

    localparam int CRTC_H_LAST_ADD = 4;
    localparam int CRTC_V_LAST_ADD = 1;

    typedef enum logic [0:0] {
        AXIS_H = 1'b0,
        AXIS_V = 1'b1
    } axis_e;

    typedef struct packed {
        logic blank;
        logic sync;
    } axis_flags_t;

    function automatic logic sync_level(input logic active,
                                        input logic off,
                                        input logic neg);
        return (active & ~off) ^ neg;
    endfunction

endpackage

// File: rtl/crtc_char_ctr.sv
module crtc_char_ctr #(
    parameter int CHAR_W = crtc_pkg::CRTC_CHAR_W
) (
    input  logic clk,
    input  logic rst,
    output logic char_en,
    output logic char_last
);
    generate
        if (CHAR_W > 1) begin : g_count
            localparam int PX_W = $clog2(CHAR_W);
            localparam logic [PX_W-1:0] PX_LAST = PX_W'(CHAR_W - 1);
            logic [PX_W-1:0] px_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    px_q <= '0;
                end else if (px_q == PX_LAST) begin
                    px_q <= '0;
                end else begin
                    px_q <= px_q + 1'b1;
                end
            end

            assign char_en   = (px_q == '0);
            assign char_last = (px_q == PX_LAST);
        end else begin : g_single
            assign char_en   = 1'b1;
            assign char_last = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/crtc_axis_ctr.sv
module crtc_axis_ctr #(
    parameter int TOT_W    = crtc_pkg::CRTC_H_W,
    parameter int CNT_W    = TOT_W + 1,
    parameter int LAST_ADD = crtc_pkg::CRTC_H_LAST_ADD,
    parameter int BE_W     = crtc_pkg::CRTC_HBE_W,
    parameter int SE_W     = crtc_pkg::CRTC_HSE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       step,
    input  logic [TOT_W-1:0]           total,
    input  logic [TOT_W-1:0]           blank_start,
    input  logic [BE_W-1:0]            blank_end,
    input  logic [TOT_W-1:0]           sync_start,
    input  logic [SE_W-1:0]            sync_end,
    output logic [CNT_W-1:0]           count,
    output logic                       wrap,
    output crtc_pkg::axis_flags_t      flags
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] cnt_nxt;
    logic             at_last;
    logic             blank_q;
    logic             sync_q;
    logic             blank_end_hit;
    logic             blank_start_hit;
    logic             sync_end_hit;
    logic             sync_start_hit;

    assign last_val = CNT_W'(total) + CNT_W'(LAST_ADD);
    assign at_last  = (cnt_q == last_val);
    assign cnt_nxt  = at_last ? '0 : cnt_q + 1'b1;

    // Blank edges look at the element being left; sync edges at the one entered.
    assign blank_end_hit   = (cnt_q[BE_W-1:0] == blank_end);
    assign blank_start_hit = (cnt_q == CNT_W'(blank_start));
    assign sync_end_hit    = (cnt_nxt[SE_W-1:0] == sync_end);
    assign sync_start_hit  = (cnt_nxt == CNT_W'(sync_start));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            blank_q <= 1'b0;
            sync_q  <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_nxt;

            if (blank_q && blank_end_hit) begin
                blank_q <= 1'b0;
            end else if (blank_start_hit) begin
                blank_q <= 1'b1;
            end

            if (sync_q && sync_end_hit) begin
                sync_q <= 1'b0;
            end else if (sync_start_hit) begin
                sync_q <= 1'b1;
            end
        end
    end

    assign count       = cnt_q;
    assign wrap        = step & at_last;
    assign flags.blank = blank_q;
    assign flags.sync  = sync_q;
endmodule

// File: rtl/crtc_sync_drive.sv
module crtc_sync_drive #(
    parameter int N_CH = 2
) (
    input  logic [N_CH-1:0] active,
    input  logic [N_CH-1:0] off,
    input  logic [N_CH-1:0] neg,
    output logic [N_CH-1:0] level
);
    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
            assign level[ch] = crtc_pkg::sync_level(active[ch], off[ch], neg[ch]);
        end
    endgenerate
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing #(
    parameter int H_W      = crtc_pkg::CRTC_H_W,
    parameter int V_W      = crtc_pkg::CRTC_V_W,
    parameter int CHAR_W   = crtc_pkg::CRTC_CHAR_W,
    parameter int RASTER_W = crtc_pkg::CRTC_RASTER_W,
    parameter int HBE_W    = crtc_pkg::CRTC_HBE_W,
    parameter int HSE_W    = crtc_pkg::CRTC_HSE_W,
    parameter int VBE_W    = crtc_pkg::CRTC_VBE_W,
    parameter int VSE_W    = crtc_pkg::CRTC_VSE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [H_W-1:0]       h_total,
    input  logic [H_W-1:0]       h_blank_start,
    input  logic [HBE_W-1:0]     h_blank_end,
    input  logic [H_W-1:0]       h_sync_start,
    input  logic [HSE_W-1:0]     h_sync_end,
    input  logic [V_W-1:0]       v_total,
    input  logic [V_W-1:0]       v_blank_start,
    input  logic [VBE_W-1:0]     v_blank_end,
    input  logic [V_W-1:0]       v_sync_start,
    input  logic [VSE_W-1:0]     v_sync_end,
    input  logic                 hsync_neg,
    input  logic                 vsync_neg,
    input  logic                 hsync_off,
    input  logic                 vsync_off,
    input  logic                 screen_off,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 blank,
    output logic [RASTER_W-1:0]  raster_line,
    output logic                 char_en
);
    import crtc_pkg::*;

    localparam int HC_W = H_W + 1;
    localparam int VC_W = V_W + 1;

    logic           char_last;
    logic [HC_W-1:0] h_count;
    logic           line_wrap;
    logic [VC_W-1:0] v_count;
    logic           frame_wrap_unused;
    axis_flags_t    h_flags;
    axis_flags_t    v_flags;
    logic [1:0]     sync_act;
    logic [1:0]     sync_off;
    logic [1:0]     sync_neg;
    logic [1:0]     sync_pin;
    logic           h_count_unused;

    crtc_char_ctr #(.CHAR_W(CHAR_W)) u_char (
        .clk       (clk),
        .rst       (rst),
        .char_en   (char_en),
        .char_last (char_last)
    );

    crtc_axis_ctr #(
        .TOT_W    (H_W),
        .CNT_W    (HC_W),
        .LAST_ADD (CRTC_H_LAST_ADD),
        .BE_W     (HBE_W),
        .SE_W     (HSE_W)
    ) u_h_axis (
        .clk         (clk),
        .rst         (rst),
        .step        (char_last),
        .total       (h_total),
        .blank_start (h_blank_start),
        .blank_end   (h_blank_end),
        .sync_start  (h_sync_start),
        .sync_end    (h_sync_end),
        .count       (h_count),
        .wrap        (line_wrap),
        .flags       (h_flags)
    );

    crtc_axis_ctr #(
        .TOT_W    (V_W),
        .CNT_W    (VC_W),
        .LAST_ADD (CRTC_V_LAST_ADD),
        .BE_W     (VBE_W),
        .SE_W     (VSE_W)
    ) u_v_axis (
        .clk         (clk),
        .rst         (rst),
        .step        (line_wrap),
        .total       (v_total),
        .blank_start (v_blank_start),
        .blank_end   (v_blank_end),
        .sync_start  (v_sync_start),
        .sync_end    (v_sync_end),
        .count       (v_count),
        .wrap        (frame_wrap_unused),
        .flags       (v_flags)
    );

    assign h_count_unused = ^h_count;

    assign sync_act[AXIS_H] = h_flags.sync;
    assign sync_act[AXIS_V] = v_flags.sync;
    assign sync_off[AXIS_H] = hsync_off;
    assign sync_off[AXIS_V] = vsync_off;
    assign sync_neg[AXIS_H] = hsync_neg;
    assign sync_neg[AXIS_V] = vsync_neg;

    crtc_sync_drive #(.N_CH(2)) u_sync (
        .active (sync_act),
        .off    (sync_off),
        .neg    (sync_neg),
        .level  (sync_pin)
    );

    assign hsync = sync_pin[AXIS_H];
    assign vsync = sync_pin[AXIS_V];
    assign blank = h_flags.blank | v_flags.blank | screen_off;

    generate
        if (VC_W > RASTER_W) begin : g_raster_trunc
            logic v_high_unused;
            assign v_high_unused = ^v_count[VC_W-1:RASTER_W];
            assign raster_line   = v_count[RASTER_W-1:0];
        end else begin : g_raster_ext
            assign raster_line = RASTER_W'(v_count);
        end
    endgenerate
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
    parameter int CHAR_W   = crtc_pkg::CRTC_CHAR_W,
    parameter int RASTER_W = crtc_pkg::CRTC_RASTER_W
) (
    input logic                clk,
    input logic                rst,
    input logic                hsync_neg,
    input logic                vsync_neg,
    input logic                hsync_off,
    input logic                vsync_off,
    input logic                screen_off,
    input logic                hsync,
    input logic                vsync,
    input logic                blank,
    input logic [RASTER_W-1:0] raster_line,
    input logic                char_en
);
    localparam int GAP_W = $clog2(CHAR_W + 1) + 1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
        end else if (char_en) begin
            gap_q <= GAP_W'(1);
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r2_char_en_due: assert property (@(posedge clk) disable iff (rst)
        (gap_q == GAP_W'(CHAR_W)) |-> char_en);

    a_r2_char_en_quiet: assert property (@(posedge clk) disable iff (rst)
        (gap_q != '0 && gap_q != GAP_W'(CHAR_W)) |-> !char_en);

    a_r3_raster_at_char: assert property (@(posedge clk) disable iff (rst)
        !$stable(raster_line) |-> char_en);

    a_r3_raster_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(raster_line) |->
            (raster_line == RASTER_W'($past(raster_line) + 1'b1) || raster_line == '0));

    a_r5_hsync_at_char: assert property (@(posedge clk) disable iff (rst)
        (!$stable(hsync) && $stable(hsync_neg) && $stable(hsync_off)) |-> char_en);

    a_r7_vsync_at_char: assert property (@(posedge clk) disable iff (rst)
        (!$stable(vsync) && $stable(vsync_neg) && $stable(vsync_off)) |-> char_en);

    a_r4_blank_at_char: assert property (@(posedge clk) disable iff (rst)
        (!$stable(blank) && $stable(screen_off)) |-> char_en);

    a_r9_hsync_held: assert property (@(posedge clk) disable iff (rst)
        (hsync_off && $stable(hsync_off) && $stable(hsync_neg)) |-> $stable(hsync));

endmodule

bind crtc_timing crtc_timing_chk #(
    .CHAR_W   (CHAR_W),
    .RASTER_W (RASTER_W)
) u_crtc_timing_chk (
    .clk         (clk),
    .rst         (rst),
    .hsync_neg   (hsync_neg),
    .vsync_neg   (vsync_neg),
    .hsync_off   (hsync_off),
    .vsync_off   (vsync_off),
    .screen_off  (screen_off),
    .hsync       (hsync),
    .vsync       (vsync),
    .blank       (blank),
    .raster_line (raster_line),
    .char_en     (char_en)
);

// File: tb/crtc_timing_bench.sv
`timescale 1ns/1ps
module crtc_timing_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  h_total;
    logic [8:0]  h_blank_start;
    logic [6:0]  h_blank_end;
    logic [8:0]  h_sync_start;
    logic [4:0]  h_sync_end;
    logic [11:0] v_total;
    logic [11:0] v_blank_start;
    logic [7:0]  v_blank_end;
    logic [11:0] v_sync_start;
    logic [3:0]  v_sync_end;
    logic        hsync_neg = 1'b0;
    logic        vsync_neg = 1'b0;
    logic        hsync_off = 1'b0;
    logic        vsync_off = 1'b0;
    logic        screen_off = 1'b0;
    logic        hsync;
    logic        vsync;
    logic        blank;
    logic [10:0] raster_line;
    logic        char_en;

    int n_checks = 0;
    int n_fails  = 0;
    int k        = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    crtc_timing u_crtc_timing (
        .clk           (clk),
        .rst           (rst),
        .h_total       (h_total),
        .h_blank_start (h_blank_start),
        .h_blank_end   (h_blank_end),
        .h_sync_start  (h_sync_start),
        .h_sync_end    (h_sync_end),
        .v_total       (v_total),
        .v_blank_start (v_blank_start),
        .v_blank_end   (v_blank_end),
        .v_sync_start  (v_sync_start),
        .v_sync_end    (v_sync_end),
        .hsync_neg     (hsync_neg),
        .vsync_neg     (vsync_neg),
        .hsync_off     (hsync_off),
        .vsync_off     (vsync_off),
        .screen_off    (screen_off),
        .hsync         (hsync),
        .vsync         (vsync),
        .blank         (blank),
        .raster_line   (raster_line),
        .char_en       (char_en)
    );

    task automatic check(input string tag, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s pixel=%0d actual=%0d expected=%0d", tag, k, actual, expected);
        end
    endtask

    task automatic cfg_base();
        h_total = 9'd5;   h_blank_start = 9'd5; h_blank_end = 7'd9;
        h_sync_start = 9'd7; h_sync_end = 5'd9;
        v_total = 12'd8;  v_blank_start = 12'd5; v_blank_end = 8'd9;
        v_sync_start = 12'd7; v_sync_end = 4'd8;
        hsync_neg = 1'b0; vsync_neg = 1'b0;
        hsync_off = 1'b0; vsync_off = 1'b0; screen_off = 1'b0;
    endtask

    task automatic cfg_alias();
        h_total = 9'd130; h_blank_start = 9'd131; h_blank_end = 7'd3;
        h_sync_start = 9'd5; h_sync_end = 5'd2;
        v_total = 12'd3;  v_blank_start = 12'd100; v_blank_end = 8'd0;
        v_sync_start = 12'd2; v_sync_end = 4'd1;
        hsync_neg = 1'b0; vsync_neg = 1'b0;
        hsync_off = 1'b0; vsync_off = 1'b0; screen_off = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        k = 0;
    endtask

    task automatic advance_to(input int target);
        while (k < target) begin
            @(negedge clk);
            #1;
            k++;
        end
    endtask

    // mode 0: base timing, mode 1: aliasing/wrap timing
    task automatic scan(input int mode, input int first, input int last);
        int cpl;
        int lines;
        int ch;
        int ln;
        bit hb;
        bit hs;
        bit vb;
        bit vs;
        cpl   = int'(h_total) + 5;
        lines = int'(v_total) + 2;
        advance_to(first);
        while (k <= last) begin
            ch = (k / 8) % cpl;
            ln = (k / (8 * cpl)) % lines;
            if (mode == 0) begin
                hb = (ch >= 6 && ch <= 9);
                hs = (ch == 7 || ch == 8);
                vb = (ln >= 6);
                vs = (ln == 7);
            end else begin
                hb = (ch >= 132 || ch <= 3);
                hs = (ch >= 5 && ch <= 33);
                vb = 1'b0;
                vs = (ln >= 2 || ln == 0);
            end
            check("R2 char_en", int'(char_en), int'((k % 8) == 0));
            check("R3 raster_line", int'(raster_line), ln);
            check("R4/R6/R10/R11 blank", int'(blank), int'(hb | vb | screen_off));
            check("R5/R8/R9 hsync", int'(hsync), int'((hs & ~hsync_off) ^ hsync_neg));
            check("R7/R8/R9 vsync", int'(vsync), int'((vs & ~vsync_off) ^ vsync_neg));
            @(negedge clk);
            #1;
            k++;
        end
    endtask

    task automatic t_reset();
        cfg_base();
        do_reset();
        check("R1 blank", int'(blank), 0);
        check("R1 hsync", int'(hsync), 0);
        check("R1 vsync", int'(vsync), 0);
        check("R1 raster_line", int'(raster_line), 0);
        check("R1 char_en", int'(char_en), 1);
    endtask

    task automatic t_base_frames();
        cfg_base();
        do_reset();
        scan(0, 0, 1599);
    endtask

    task automatic t_polarity();
        cfg_base();
        hsync_neg = 1'b1;
        vsync_neg = 1'b1;
        do_reset();
        scan(0, 0, 799);
    endtask

    task automatic t_sync_off();
        cfg_base();
        hsync_neg = 1'b1;
        hsync_off = 1'b1;
        vsync_off = 1'b1;
        do_reset();
        scan(0, 0, 799);
    endtask

    task automatic t_screen_off();
        cfg_base();
        screen_off = 1'b1;
        do_reset();
        scan(0, 0, 799);
    endtask

    task automatic t_alias_wrap();
        cfg_alias();
        do_reset();
        scan(1, 5400, 10799);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired pixel=%0d actual=running expected=done", k);
        finish_run();
    end

    initial begin
        t_reset();
        t_base_frames();
        t_polarity();
        t_sync_off();
        t_screen_off();
        t_alias_wrap();
        finish_run();
    end

endmodule